// File: doc/BRIEF.md
# Serial Transmitter with Address-Frame Marking

This block turns bytes into asynchronous serial frames on a single line that rests high. Each frame opens with a low start bit and carries 1 to 8 data bits, least significant first. An optional parity bit and one or two high stop bits follow. The bit time comes from a 16-bit divisor value `baud_div`. A divisor of zero gives a bit time of 16 clocks. Any other value D gives a bit time of (D+1)*8 clocks. Bytes enter through a valid/ready write port. They are stored either in a small FIFO or in a one-entry holding buffer.

For buses shared by several receivers, the block can mark the next frame as an address. Software requests this with a one-cycle pulse on `wake_set`. The pulse is stored until the next frame moves into the shifter, and then it is cleared. In idle-line mode the marked frame is preceded by exactly 11 high bit times. In address-bit mode each frame carries an extra bit after its data bits. That bit is 1 for a marked frame and 0 for all other frames. When the FIFO is in use, a programmable pause of 0 to 255 bit times can be placed between consecutive frames. A loopback output repeats the line for an internal receive path.

Top module: `sertx_wake`

## Requirements
- R1: While `rst` is high and right after it, `txd`, `loop_rxd`, `tx_rdy`, `tx_empty` and `wr_ready` are all 1.
- R2: Every bit on `txd` lasts exactly 16 clocks when `baud_div` is 0, and (`baud_div`+1)*8 clocks otherwise. The line changes only on a bit boundary.
- R3: A frame is a 0 start bit followed by `char_len`+1 data bits, least significant bit first (`char_len` is 0..7).
- R4: With `par_en`=1, a parity bit follows the data bits (and the address bit, if present). With `par_even`=1 the parity bit equals the XOR of the data bits. With `par_even`=0 it equals the inverse of that XOR.
- R5: One stop bit (value 1) ends the frame when `two_stop`=0, and two stop bits end it when `two_stop`=1.
- R6: `tx_rdy` is 1 exactly when no byte waits in the buffer. `tx_empty` is 1 only when no byte waits and no frame or gap is in progress. In single-buffer mode (`fifo_mode`=0), `wr_ready` drops while one byte is held.
- R7: A frame that is under way always completes. A byte that is waiting starts on the bit boundary right after the last stop bit. In single-buffer mode `gap_delay` has no effect.
- R8: In idle-line mode (`addr_mode`=0), a frame taken while a wake request is pending starts exactly 11 bit times after the previous frame's last stop bit ends.
- R9: A wake request applies to one frame only. The frame after it gets no gap and an address bit of 0.
- R10: In address-bit mode (`addr_mode`=1), one bit follows the data bits. It is 1 for a frame taken while a wake request is pending and 0 otherwise. No extra idle time is inserted.
- R11: In FIFO mode, with `gap_delay`=N, consecutive frames are separated by exactly N idle bit times.
- R12: `loop_rxd` equals `txd` while `loopback_en`=1, and it is held at 1 while `loopback_en`=0.
- R13: While `tx_en`=0, `txd` stays at 1 and buffered bytes are kept. Once `tx_en` returns to 1, the bytes are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable |
| fifo_mode | input | 1 | 1: FIFO buffering, 0: single holding buffer |
| wr_valid | input | 1 | Byte offered on wr_data |
| wr_data | input | 8 | Byte to send |
| wr_ready | output | 1 | Buffer can accept a byte |
| char_len | input | 3 | Data bits minus one |
| par_en | input | 1 | Parity bit enable |
| par_even | input | 1 | 1: even parity, 0: odd parity |
| two_stop | input | 1 | 1: two stop bits |
| addr_mode | input | 1 | 1: address-bit marking, 0: idle-gap marking |
| loopback_en | input | 1 | Copy line to loop_rxd |
| wake_set | input | 1 | Pulse: mark the next frame taken as an address |
| gap_delay | input | 8 | Idle bit times between FIFO frames |
| baud_div | input | 16 | Bit time divisor |
| txd | output | 1 | Serial line |
| loop_rxd | output | 1 | Loopback copy of the line |
| tx_rdy | output | 1 | No byte waiting in the buffer |
| tx_empty | output | 1 | Buffer and shifter both empty |

## Verification
Some properties are checked by the assertions on every cycle. The line never moves between bit-time ticks, and it is forced high when the transmitter is disabled or inside an address gap. `tx_empty` implies `tx_rdy`, the single buffer refuses a second byte, and the loopback output follows the line. Other behaviour only the directed scenarios can show. This includes the exact bit layout for each format, the parity values, and the 11-bit gap measured start to start. It also covers the one-shot clearing of the wake request, the address-bit value, the FIFO pause, and bytes held while the transmitter is disabled.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int DATA_W   = 8;
  localparam int FRAME_W  = 13;  // start + 8 data + addr + parity + 2 stop
  localparam int LEN_W    = 4;
  localparam int GAP_BITS = 11;
  localparam int GAP_W    = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_GAP, ST_SEND} tx_state_e;

  typedef struct packed {
    logic [2:0] len_m1;
    logic       par_en;
    logic       par_even;
    logic       two_stop;
    logic       addr_mode;
  } fmt_t;

  typedef struct packed {
    logic [LEN_W-1:0]   len;
    logic [FRAME_W-1:0] bits;
  } frame_t;

  // Bit 0 of the result is the first bit sent on the line.
  function automatic frame_t pack_frame(input logic [DATA_W-1:0] d,
                                        input fmt_t f, input logic mark);
    frame_t             r;
    logic [LEN_W-1:0]   pos;
    logic [DATA_W-1:0]  dd;
    logic               p;
    r.bits    = '1;
    r.bits[0] = 1'b0;
    pos       = LEN_W'(1);
    dd        = d;
    p         = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i <= int'(f.len_m1)) begin
        r.bits[pos] = dd[0];
        p           = p ^ dd[0];
        pos         = pos + LEN_W'(1);
      end
      dd = dd >> 1;
    end
    if (f.addr_mode) begin
      r.bits[pos] = mark;
      pos         = pos + LEN_W'(1);
    end
    if (f.par_en) begin
      r.bits[pos] = f.par_even ? p : ~p;
      pos         = pos + LEN_W'(1);
    end
    r.len = pos + (f.two_stop ? LEN_W'(2) : LEN_W'(1));
    return r;
  endfunction
endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int CNT_W = DIV_W + 4;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  always_comb begin
    if (div == '0) last = CNT_W'(15);
    else           last = ((CNT_W'(div) + CNT_W'(1)) << 3) - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= last) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + CNT_W'(1);
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          single,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          full,
  output logic          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_wr, do_rd;

  assign full    = single ? (cnt != '0) : (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (do_rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      unique case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/sertx_engine.sv
module sertx_engine
  import sertx_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  input  logic              avail,
  input  logic [DATA_W-1:0] din,
  input  fmt_t              fmt,
  input  logic              fifo_mode,
  input  logic [DLY_W-1:0]  gap_delay,
  input  logic              wake_set,
  output logic              pop,
  output logic              txd,
  output logic              txd_nx,
  output logic              busy,
  output logic              in_gap
);
  tx_state_e          st, st_n;
  logic [FRAME_W-1:0] sh, sh_n;
  logic [LEN_W-1:0]   rem, rem_n;
  logic [GAP_W-1:0]   gap, gap_n;
  logic [DLY_W-1:0]   dly, dly_n;
  logic               wake_q, wake_n;
  logic               launch;
  frame_t             fr;

  always_comb begin
    fr     = pack_frame(din, fmt, wake_q);
    st_n   = st;
    sh_n   = sh;
    rem_n  = rem;
    gap_n  = gap;
    dly_n  = dly;
    txd_nx = txd;
    pop    = 1'b0;
    launch = 1'b0;
    wake_n = wake_q | wake_set;
    if (!en) begin
      st_n   = ST_IDLE;
      txd_nx = 1'b1;
      dly_n  = '0;
    end else if (tick) begin
      unique case (st)
        ST_IDLE: begin
          if (dly > DLY_W'(1)) dly_n = dly - DLY_W'(1);
          else begin
            dly_n  = '0;
            launch = avail;
          end
        end
        ST_GAP: begin
          if (gap == '0) begin
            st_n   = ST_SEND;
            txd_nx = 1'b0;
          end else gap_n = gap - GAP_W'(1);
        end
        ST_SEND: begin
          if (rem == '0) begin
            if (fifo_mode && gap_delay != '0) begin
              st_n   = ST_IDLE;
              txd_nx = 1'b1;
              dly_n  = gap_delay;
            end else if (avail) launch = 1'b1;
            else begin
              st_n   = ST_IDLE;
              txd_nx = 1'b1;
            end
          end else begin
            txd_nx = sh[0];
            sh_n   = {1'b1, sh[FRAME_W-1:1]};
            rem_n  = rem - LEN_W'(1);
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
    if (launch) begin
      pop    = 1'b1;
      wake_n = wake_set;
      sh_n   = {1'b1, fr.bits[FRAME_W-1:1]};
      rem_n  = fr.len - LEN_W'(1);
      if (wake_q && !fmt.addr_mode) begin
        st_n   = ST_GAP;
        gap_n  = GAP_W'(GAP_BITS - 1);
        txd_nx = 1'b1;
      end else begin
        st_n   = ST_SEND;
        txd_nx = fr.bits[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      sh     <= '1;
      rem    <= '0;
      gap    <= '0;
      dly    <= '0;
      wake_q <= 1'b0;
      txd    <= 1'b1;
    end else begin
      st     <= st_n;
      sh     <= sh_n;
      rem    <= rem_n;
      gap    <= gap_n;
      dly    <= dly_n;
      wake_q <= wake_n;
      txd    <= txd_nx;
    end
  end

  assign busy   = (st != ST_IDLE);
  assign in_gap = (st == ST_GAP);
endmodule

// File: rtl/sertx_wake.sv
module sertx_wake
  import sertx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DIV_W = 16,
  parameter int DLY_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              fifo_mode,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic [2:0]        char_len,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              two_stop,
  input  logic              addr_mode,
  input  logic              loopback_en,
  input  logic              wake_set,
  input  logic [DLY_W-1:0]  gap_delay,
  input  logic [DIV_W-1:0]  baud_div,
  output logic              txd,
  output logic              loop_rxd,
  output logic              tx_rdy,
  output logic              tx_empty
);
  logic              bit_tick, in_gap, busy, pop, txd_nx;
  logic              fifo_full, fifo_empty;
  logic [DATA_W-1:0] head;
  fmt_t              fmt;

  assign fmt = '{len_m1: char_len, par_en: par_en, par_even: par_even,
                 two_stop: two_stop, addr_mode: addr_mode};

  sertx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst(rst), .en(tx_en), .div(baud_div), .tick(bit_tick)
  );

  sertx_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .single(!fifo_mode),
    .wr_en(wr_valid), .wr_data(wr_data),
    .rd_en(pop), .rd_data(head), .full(fifo_full), .empty(fifo_empty)
  );

  sertx_engine #(.DLY_W(DLY_W)) u_eng (
    .clk(clk), .rst(rst), .en(tx_en), .tick(bit_tick), .avail(!fifo_empty),
    .din(head), .fmt(fmt), .fifo_mode(fifo_mode), .gap_delay(gap_delay),
    .wake_set(wake_set), .pop(pop), .txd(txd), .txd_nx(txd_nx),
    .busy(busy), .in_gap(in_gap)
  );

  always_ff @(posedge clk) begin
    if (rst) loop_rxd <= 1'b1;
    else     loop_rxd <= loopback_en ? txd_nx : 1'b1;
  end

  assign wr_ready = !fifo_full;
  assign tx_rdy   = fifo_empty;
  assign tx_empty = fifo_empty && !busy;
endmodule

// File: rtl/sertx_wake_chk.sv
module sertx_wake_chk (
  input logic clk,
  input logic rst,
  input logic tx_en,
  input logic fifo_mode,
  input logic loopback_en,
  input logic wr_ready,
  input logic tx_rdy,
  input logic tx_empty,
  input logic txd,
  input logic loop_rxd,
  input logic bit_tick,
  input logic in_gap
);
  a_r13_line_high_when_off: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> txd);

  a_r2_moves_on_tick_only: assert property (@(posedge clk) disable iff (rst)
    $past(tx_en) && !$past(bit_tick) |-> $stable(txd));

  a_r6_empty_needs_rdy: assert property (@(posedge clk) disable iff (rst)
    tx_empty |-> tx_rdy);

  a_r6_single_holds_one: assert property (@(posedge clk) disable iff (rst)
    !fifo_mode && !tx_rdy |-> !wr_ready);

  a_r8_gap_is_high: assert property (@(posedge clk) disable iff (rst)
    in_gap |-> txd);

  a_r12_loop_follows: assert property (@(posedge clk) disable iff (rst)
    $past(loopback_en) |-> (loop_rxd == txd));

  a_r12_loop_quiet: assert property (@(posedge clk) disable iff (rst)
    !$past(loopback_en) |-> loop_rxd);
endmodule

bind sertx_wake sertx_wake_chk u_chk (
  .clk(clk), .rst(rst), .tx_en(tx_en), .fifo_mode(fifo_mode),
  .loopback_en(loopback_en), .wr_ready(wr_ready), .tx_rdy(tx_rdy),
  .tx_empty(tx_empty), .txd(txd), .loop_rxd(loop_rxd),
  .bit_tick(bit_tick), .in_gap(in_gap)
);

// File: tb/sim_sertx_wake.sv
`timescale 1ns/1ps
module sim_sertx_wake;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_en = 1'b0, fifo_mode = 1'b1, wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_ready;
  logic [2:0] char_len = 3'd7;
  logic       par_en = 1'b0, par_even = 1'b0, two_stop = 1'b0, addr_mode = 1'b0;
  logic       loopback_en = 1'b0, wake_set = 1'b0;
  logic [7:0] gap_delay = '0;
  logic [15:0] baud_div = 16'd1;
  logic       txd, loop_rxd, tx_rdy, tx_empty;

  int cyc = 0, tests = 0, fails = 0, P = 16;
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sertx_wake u0 (
    .clk(clk), .rst(rst), .tx_en(tx_en), .fifo_mode(fifo_mode),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .char_len(char_len), .par_en(par_en), .par_even(par_even),
    .two_stop(two_stop), .addr_mode(addr_mode), .loopback_en(loopback_en),
    .wake_set(wake_set), .gap_delay(gap_delay), .baud_div(baud_div),
    .txd(txd), .loop_rxd(loop_rxd), .tx_rdy(tx_rdy), .tx_empty(tx_empty)
  );

  task automatic chk(input string tag, input bit ok, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void expf(input logic [7:0] d, output logic [12:0] b, output int len);
    logic p = 1'b0;
    b = '1; b[0] = 1'b0; len = 1;
    for (int i = 0; i <= int'(char_len); i++) begin
      b[len] = d[i]; p ^= d[i]; len++;
    end
    if (addr_mode) len++;   // caller fills the address bit
    if (par_en) begin b[len] = par_even ? p : ~p; len++; end
    len += two_stop ? 2 : 1;
  endfunction

  task automatic set_div(input logic [15:0] v);
    @(negedge clk);
    baud_div = v;
    P = (v == 0) ? 16 : (int'(v) + 1) * 8;
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_fall(input string tag, output int t);
    int n = 0;
    @(negedge clk);
    while (txd !== 1'b0 && n < 20000) begin @(negedge clk); n++; end
    if (n >= 20000) chk({tag, " start bit timeout"}, 1'b0, n, 0);
    t = cyc;
  endtask

  task automatic grab(input int t, input int len, output logic [12:0] b);
    b = '1;
    for (int i = 0; i < len; i++) begin
      while (cyc < t + P / 2 + i * P) @(negedge clk);
      b[i] = txd;
    end
  endtask

  task automatic settle;
    int n = 0;
    @(negedge clk);
    while (!tx_empty && n < 20000) begin @(negedge clk); n++; end
    repeat (2 * P) @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", txd && loop_rxd && tx_rdy && tx_empty && wr_ready,
        {txd, loop_rxd, tx_rdy, tx_empty, wr_ready}, 5'h1f);
    rst = 1'b0; tx_en = 1'b1;
    @(negedge clk);
    chk("R1 after reset idle", txd && tx_empty, {txd, tx_empty}, 2'b11);
  endtask

  task automatic t_rate(input logic [15:0] v);
    int t, w = 0;
    set_div(v);
    push(8'h01);
    wait_fall("R2", t);
    while (txd == 1'b0 && w < 5000) begin @(negedge clk); w++; end
    chk($sformatf("R2 start bit width div=%0d", v), w == P, w, P);
    settle();
  endtask

  task automatic t_format(input string tag, input logic [7:0] d);
    int t, len; logic [12:0] got, exp;
    expf(d, exp, len);
    push(d);
    wait_fall(tag, t);
    grab(t, len, got);
    chk(tag, got == exp, int'(got), int'(exp));
    settle();
  endtask

  task automatic t_single;
    int t1, t2, len; logic [12:0] got, exp;
    fifo_mode = 1'b0; gap_delay = 8'd5;
    expf(8'h3c, exp, len);
    push(8'h3c);
    chk("R6 tx_empty low once loaded", !tx_empty, tx_empty, 0);
    wait_fall("R6", t1);
    chk("R6 buffer free in first frame", tx_rdy && !tx_empty, {tx_rdy, tx_empty}, 2'b10);
    push(8'hc3);
    chk("R6 single buffer full", !tx_rdy && !wr_ready, {tx_rdy, wr_ready}, 2'b00);
    grab(t1, len, got);
    chk("R7 first frame intact", got == exp, int'(got), int'(exp));
    wait_fall("R7", t2);
    chk("R7 back-to-back, delay ignored", t2 - t1 == len * P, t2 - t1, len * P);
    expf(8'hc3, exp, len);
    grab(t2, len, got);
    chk("R7 second frame", got == exp, int'(got), int'(exp));
    repeat (P) @(negedge clk);
    chk("R6 tx_empty after drain", tx_empty && tx_rdy && txd, {tx_empty, tx_rdy, txd}, 3'b111);
    fifo_mode = 1'b1; gap_delay = '0;
    settle();
  endtask

  task automatic t_idle_wake;
    int t1, t2, t3, len; logic [12:0] got, exp;
    addr_mode = 1'b0;
    push(8'h11); push(8'h22); push(8'h33);
    wait_fall("R8", t1);
    @(negedge clk); wake_set = 1'b1; @(negedge clk); wake_set = 1'b0;
    expf(8'h11, exp, len);
    grab(t1, len, got);
    wait_fall("R8", t2);
    chk("R8 eleven idle bits before address", t2 - t1 == (len + 11) * P, t2 - t1, (len + 11) * P);
    expf(8'h22, exp, len);
    grab(t2, len, got);
    chk("R8 marked frame content", got == exp, int'(got), int'(exp));
    wait_fall("R9", t3);
    chk("R9 no gap after marked frame", t3 - t2 == len * P, t3 - t2, len * P);
    settle();
  endtask

  task automatic t_addr_bit;
    int t1, t2, t3, len; logic [12:0] g1, g2, g3;
    addr_mode = 1'b1;
    push(8'h5a); push(8'ha5); push(8'h0f);
    wait_fall("R10", t1);
    @(negedge clk); wake_set = 1'b1; @(negedge clk); wake_set = 1'b0;
    len = 11;
    grab(t1, len, g1);
    wait_fall("R10", t2);
    chk("R10 no idle insertion", t2 - t1 == len * P, t2 - t1, len * P);
    grab(t2, len, g2);
    wait_fall("R9", t3);
    grab(t3, len, g3);
    chk("R10 bit after data, plain frame", g1[9] == 1'b0, g1[9], 0);
    chk("R10 bit after data, marked frame", g2[9] == 1'b1 && g2[8:1] == 8'ha5, int'(g2), 1);
    chk("R9 mark cleared on next frame", g3[9] == 1'b0 && g3[8:1] == 8'h0f, int'(g3), 8'h0f << 1);
    addr_mode = 1'b0;
    settle();
  endtask

  task automatic t_delay;
    int t1, t2, len; logic [12:0] got, exp;
    gap_delay = 8'd3;
    push(8'h81); push(8'h7e);
    wait_fall("R11", t1);
    expf(8'h81, exp, len);
    grab(t1, len, got);
    wait_fall("R11", t2);
    chk("R11 FIFO pause of 3 bits", t2 - t1 == (len + 3) * P, t2 - t1, (len + 3) * P);
    gap_delay = '0;
    settle();
  endtask

  task automatic t_loop;
    int t, len; logic [12:0] got, exp;
    loopback_en = 1'b1;
    push(8'h40);
    wait_fall("R12", t);
    chk("R12 loop copy low in start bit", loop_rxd == 1'b0, loop_rxd, 0);
    expf(8'h40, exp, len);
    grab(t, len, got);
    settle();
    loopback_en = 1'b0;
    push(8'h40);
    wait_fall("R12", t);
    chk("R12 loop copy quiet when off", loop_rxd == 1'b1, loop_rxd, 1);
    settle();
  endtask

  task automatic t_disabled;
    int t, len, lows = 0; logic [12:0] got, exp;
    tx_en = 1'b0;
    push(8'h96);
    repeat (200) begin @(negedge clk); if (!txd) lows++; end
    chk("R13 line high while disabled", lows == 0, lows, 0);
    chk("R13 byte held while disabled", !tx_rdy, tx_rdy, 0);
    tx_en = 1'b1;
    wait_fall("R13", t);
    expf(8'h96, exp, len);
    grab(t, len, got);
    chk("R13 held byte sent after enable", got == exp, int'(got), int'(exp));
    settle();
  endtask

  initial begin
    t_reset();
    t_rate(16'd0);
    t_rate(16'd2);
    set_div(16'd1);
    t_format("R3 8 data bits 0xA5", 8'ha5);
    char_len = 3'd4;
    t_format("R3 5 data bits 0x13", 8'h13);
    char_len = 3'd6; par_en = 1'b1; par_even = 1'b1; two_stop = 1'b1;
    t_format("R4 R5 7 bits even parity two stops", 8'h5b);
    char_len = 3'd7; par_even = 1'b0; two_stop = 1'b0;
    t_format("R4 8 bits odd parity 0xFF", 8'hff);
    par_en = 1'b0;
    t_single();
    t_idle_wake();
    t_addr_bit();
    t_delay();
    t_loop();
    t_disabled();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule